// File: doc/BRIEF.md
# Rotate and Rotate-Through-Carry Unit

This block performs the rotate family of integer operations on a 16-bit operand in one registered pipeline stage. Four operations are offered: plain rotate left, plain rotate right, and the two rotates in which the carry flag joins the operand as a 17th bit. With each accepted operand the unit also takes an 8-bit count and the incoming carry and overflow flags. One cycle later it returns the rotated value, the updated carry and overflow flags, and a strobe that tells the surrounding core whether the result should be written back.

Plain rotates and carry rotates reduce the count in different ways. A plain rotate uses only the low four bits of the count. A carry rotate first keeps the low five bits and then reduces them modulo 17, because the loop it rotates is 17 bits long. When the effective count is zero the operand and both flags pass through unchanged and the write-back strobe stays low. The overflow flag changes only for single-step rotates. The zero, sign and parity flags are not touched by these operations and are not produced here.

Top module: `rot_unit`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` and `out_commit` are 0 until an operand has been accepted.
- R2: `out_valid` equals the previous cycle's `in_valid`. Outputs are updated only on a cycle after `in_valid` was 1, and otherwise they hold their values.
- R3: Operation codes are 00 rotate left, 01 rotate right, 10 rotate left through carry and 11 rotate right through carry. For codes 00 and 01 the effective count n is `in_count[3:0]`, and the result is the operand rotated by n bit positions.
- R4: For codes 00 and 01 with n = 0, `out_data` equals the operand, `out_cf` equals `in_cf`, `out_of` equals `in_of`, and `out_commit` is 0. For any nonzero effective count `out_commit` is 1.
- R5: After a nonzero plain rotate, `out_cf` equals result bit 0 for code 00 and result bit 15 for code 01.
- R6: For codes 10 and 11 the effective count n is `in_count[4:0]` modulo 17. With n = 0 the data and both flags pass through unchanged and `out_commit` is 0.
- R7: Code 10 with n in 1..16 rotates the 17-bit value {carry, operand} left by n. The result is its low 16 bits, and `out_cf` is operand bit (16 - n).
- R8: Code 11 with n in 1..16 rotates {carry, operand} right by n. The result is its low 16 bits, and `out_cf` is operand bit (n - 1).
- R9: When the effective count is exactly 1, `out_of` is result bit 15 XOR operand bit 15. For any other effective count `out_of` equals `in_of`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| in_op | input | 2 | Operation code (see R3) |
| in_count | input | 8 | Rotate count before reduction |
| in_data | input | 16 | Operand |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 16 | Rotated result |
| out_cf | output | 1 | Updated carry flag |
| out_of | output | 1 | Updated overflow flag |
| out_commit | output | 1 | Result should be written back (effective count nonzero) |

## Verification
The assertions check on every cycle that the unit stays silent until an operand arrives and that its valid output is the input valid delayed by one cycle. They also check that outputs hold while no operand is offered, that a plain rotate's carry mirrors the correct end bit of its result, that a zero plain count passes data and carry through, and that overflow keeps its old value unless the plain count is one. Only the bench can show that the rotated values and through-carry flags are correct across all counts. That includes the modulo-17 wrap at counts 16 and 17, the upper count bits being ignored, and the values reached by the 17-bit carry loop, all of which it compares against a bit-by-bit reference model.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    OP_ROT_LEFT   = 2'b00,
    OP_ROT_RIGHT  = 2'b01,
    OP_CARRY_LEFT = 2'b10,
    OP_CARRY_RIGHT= 2'b11
  } rot_op_e;

  // bit 1 of the code selects the carry loop, bit 0 the direction
  function automatic logic op_uses_carry(input rot_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_right(input rot_op_e op);
    return op[0];
  endfunction

endpackage

// File: rtl/rot_rst_sync.sv
module rot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/rot_count_reduce.sv
module rot_count_reduce #(
  parameter int WIDTH = 16,
  parameter int LG    = $clog2(WIDTH),
  parameter int EW    = LG + 1
) (
  input  logic [LG:0]   raw_cnt,
  input  logic          use_carry,
  output logic [EW-1:0] eff_cnt,
  output logic          cnt_zero,
  output logic          cnt_one
);

  localparam logic [EW-1:0] LOOP_LEN = EW'(WIDTH + 1);

  logic [EW-1:0] plain_cnt;
  logic [EW-1:0] carry_cnt;

  // Plain rotate: modulo WIDTH, i.e. drop the top bit.
  always_comb begin
    plain_cnt = {1'b0, raw_cnt[LG-1:0]};
  end

  // Carry rotate: mask to LG+1 bits (< 2*(WIDTH+1)), then a single
  // conditional subtract gives the modulo (WIDTH+1) remainder.
  always_comb begin
    if (raw_cnt >= LOOP_LEN) begin
      carry_cnt = raw_cnt - LOOP_LEN;
    end else begin
      carry_cnt = raw_cnt;
    end
  end

  always_comb begin
    eff_cnt  = use_carry ? carry_cnt : plain_cnt;
    cnt_zero = (eff_cnt == '0);
    cnt_one  = (eff_cnt == EW'(1));
  end

endmodule

// File: rtl/rot_datapath.sv
module rot_datapath #(
  parameter int WIDTH = 16,
  parameter int EW    = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] op_data,
  input  logic             op_cf,
  input  logic [EW-1:0]    amt,
  input  logic             go_right,
  output logic [WIDTH-1:0] plain_res,
  output logic [WIDTH:0]   loop_res
);

  localparam logic [EW-1:0] PLAIN_SPAN = EW'(WIDTH);
  localparam logic [EW-1:0] LOOP_SPAN  = EW'(WIDTH + 1);

  logic [EW-1:0]  plain_back;
  logic [EW-1:0]  loop_back;
  logic [WIDTH:0] loop_src;
  logic [WIDTH-1:0] rol_v, ror_v;
  logic [WIDTH:0]   rcl_v, rcr_v;

  // Complementary shift distances; a zero amount yields a full-span
  // back shift, which empties that term and leaves the source intact.
  always_comb begin
    plain_back = PLAIN_SPAN - amt;
    loop_back  = LOOP_SPAN - amt;
    loop_src   = {op_cf, op_data};
  end

  always_comb begin
    rol_v = (op_data << amt) | (op_data >> plain_back);
    ror_v = (op_data >> amt) | (op_data << plain_back);
    rcl_v = (loop_src << amt) | (loop_src >> loop_back);
    rcr_v = (loop_src >> amt) | (loop_src << loop_back);
  end

  always_comb begin
    plain_res = go_right ? ror_v : rol_v;
    loop_res  = go_right ? rcr_v : rcl_v;
  end

endmodule

// File: rtl/rot_flag_gen.sv
module rot_flag_gen #(
  parameter int WIDTH = 16
) (
  input  logic             use_carry,
  input  logic             go_right,
  input  logic             cnt_zero,
  input  logic             cnt_one,
  input  logic [WIDTH-1:0] op_data,
  input  logic             op_cf,
  input  logic             op_of,
  input  logic [WIDTH-1:0] plain_res,
  input  logic [WIDTH:0]   loop_res,
  output logic [WIDTH-1:0] res_data,
  output logic             res_cf,
  output logic             res_of,
  output logic             res_commit
);

  logic [WIDTH-1:0] sel_data;
  logic             sel_cf;

  always_comb begin
    if (use_carry) begin
      sel_data = loop_res[WIDTH-1:0];
      sel_cf   = loop_res[WIDTH];
    end else begin
      sel_data = plain_res;
      sel_cf   = go_right ? plain_res[WIDTH-1] : plain_res[0];
    end
  end

  always_comb begin
    if (cnt_zero) begin
      res_data   = op_data;
      res_cf     = op_cf;
      res_of     = op_of;
      res_commit = 1'b0;
    end else begin
      res_data   = sel_data;
      res_cf     = sel_cf;
      res_of     = cnt_one ? (sel_data[WIDTH-1] ^ op_data[WIDTH-1]) : op_of;
      res_commit = 1'b1;
    end
  end

endmodule

// File: rtl/rot_unit.sv
module rot_unit #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [CNT_W-1:0] in_count,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_cf,
  input  logic             in_of,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             out_cf,
  output logic             out_of,
  output logic             out_commit
);
  import rot_pkg::*;

  localparam int LG = $clog2(WIDTH);
  localparam int EW = LG + 1;

  logic          rst_sync_n;
  rot_op_e       op_e;
  logic          use_carry, go_right;
  logic [EW-1:0] eff_cnt;
  logic          cnt_zero, cnt_one;
  logic [WIDTH-1:0] plain_res;
  logic [WIDTH:0]   loop_res;
  logic [WIDTH-1:0] res_data;
  logic             res_cf, res_of, res_commit;

  logic             nxt_valid, nxt_cf, nxt_of, nxt_commit;
  logic [WIDTH-1:0] nxt_data;
  logic             valid_q, cf_q, of_q, commit_q;
  logic [WIDTH-1:0] data_q;

  rot_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    op_e      = rot_op_e'(in_op);
    use_carry = op_uses_carry(op_e);
    go_right  = op_is_right(op_e);
  end

  rot_count_reduce #(.WIDTH(WIDTH), .LG(LG), .EW(EW)) u_reduce (
    .raw_cnt   (in_count[LG:0]),
    .use_carry (use_carry),
    .eff_cnt   (eff_cnt),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one)
  );

  rot_datapath #(.WIDTH(WIDTH), .EW(EW)) u_path (
    .op_data   (in_data),
    .op_cf     (in_cf),
    .amt       (eff_cnt),
    .go_right  (go_right),
    .plain_res (plain_res),
    .loop_res  (loop_res)
  );

  rot_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .use_carry  (use_carry),
    .go_right   (go_right),
    .cnt_zero   (cnt_zero),
    .cnt_one    (cnt_one),
    .op_data    (in_data),
    .op_cf      (in_cf),
    .op_of      (in_of),
    .plain_res  (plain_res),
    .loop_res   (loop_res),
    .res_data   (res_data),
    .res_cf     (res_cf),
    .res_of     (res_of),
    .res_commit (res_commit)
  );

  // Next-state: result registers load only when an operand is accepted.
  always_comb begin
    nxt_valid = in_valid;
    if (in_valid) begin
      nxt_data   = res_data;
      nxt_cf     = res_cf;
      nxt_of     = res_of;
      nxt_commit = res_commit;
    end else begin
      nxt_data   = data_q;
      nxt_cf     = cf_q;
      nxt_of     = of_q;
      nxt_commit = commit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      data_q   <= '0;
      cf_q     <= 1'b0;
      of_q     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      valid_q  <= nxt_valid;
      data_q   <= nxt_data;
      cf_q     <= nxt_cf;
      of_q     <= nxt_of;
      commit_q <= nxt_commit;
    end
  end

  assign out_valid  = valid_q;
  assign out_data   = data_q;
  assign out_cf     = cf_q;
  assign out_of     = of_q;
  assign out_commit = commit_q;

endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_q,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic [CNT_W-1:0] in_count,
  input logic [WIDTH-1:0] in_data,
  input logic             in_cf,
  input logic             in_of,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic             out_cf,
  input logic             out_of,
  input logic             out_commit
);

  localparam int LG = $clog2(WIDTH);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !past_ok |-> (!out_valid && !out_commit));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_q)
    past_ok |-> (out_valid == $past(in_valid)));

  // R2
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && !$past(in_valid)) |->
      ($stable(out_data) && $stable(out_cf) && $stable(out_of) && $stable(out_commit)));

  // R4
  commit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_commit && !out_valid |-> !$past(in_valid));

  // R4
  plain_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && $past(in_valid) && !$past(in_op[1]) &&
     (($past(in_count) & CNT_W'((1 << LG) - 1)) == '0)) |->
      (out_data == $past(in_data) && out_cf == $past(in_cf) && !out_commit));

  // R5
  rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && $past(in_valid) && $past(in_op) == 2'b00 && out_commit) |->
      (out_cf == out_data[0]));

  // R5
  ror_carry_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && $past(in_valid) && $past(in_op) == 2'b01 && out_commit) |->
      (out_cf == out_data[WIDTH-1]));

  // R9
  plain_of_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && $past(in_valid) && !$past(in_op[1]) &&
     $past(in_count[LG-1:0]) != LG'(1)) |->
      (out_of == $past(in_of)));

endmodule

bind rot_unit rot_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_sync_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_count   (in_count),
  .in_data    (in_data),
  .in_cf      (in_cf),
  .in_of      (in_of),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_cf     (out_cf),
  .out_of     (out_of),
  .out_commit (out_commit)
);

// File: tb/tb_rot_unit.sv
module tb_rot_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [7:0]  in_count;
  logic [15:0] in_data;
  logic        in_cf;
  logic        in_of;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_cf;
  logic        out_of;
  logic        out_commit;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  rot_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_count   (in_count),
    .in_data    (in_data),
    .in_cf      (in_cf),
    .in_of      (in_of),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_cf     (out_cf),
    .out_of     (out_of),
    .out_commit (out_commit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: step the rotation one bit at a time.
  // Returns {commit, of, cf, data}.
  function automatic logic [18:0] ref_model(input logic [1:0] op, input logic [7:0] cnt,
                                            input logic [15:0] d, input logic c, input logic o);
    int          n;
    logic [15:0] r;
    logic        k;
    logic        t;
    r = d;
    k = c;
    if (op[1] == 1'b0) n = int'(cnt[3:0]);
    else               n = int'(cnt[4:0]) % 17;
    if (n == 0) return {1'b0, o, c, d};
    for (int i = 0; i < n; i++) begin
      case (op)
        2'b00: r = {r[14:0], r[15]};
        2'b01: r = {r[0], r[15:1]};
        2'b10: begin t = r[15]; r = {r[14:0], k}; k = t; end
        default: begin t = r[0]; r = {k, r[15:1]}; k = t; end
      endcase
    end
    if (op == 2'b00) k = r[0];
    if (op == 2'b01) k = r[15];
    return {1'b1, (n == 1) ? (r[15] ^ d[15]) : o, k, r};
  endfunction

  function automatic string tag_for(input logic [1:0] op, input logic [7:0] cnt);
    int n;
    if (op[1] == 1'b0) n = int'(cnt[3:0]);
    else               n = int'(cnt[4:0]) % 17;
    case (op)
      2'b00:   return (n == 0) ? "R4" : "R3 R5";
      2'b01:   return (n == 0) ? "R4" : "R3 R5";
      2'b10:   return (n == 0) ? "R6" : "R6 R7";
      default: return (n == 0) ? "R6" : "R6 R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] op, input logic [7:0] cnt,
                         input logic [15:0] d, input logic c, input logic o);
    logic [18:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_count = cnt;
    in_data  = d;
    in_cf    = c;
    in_of    = o;
    e = ref_model(op, cnt, d, c, o);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag_for(op, cnt), {13'd0, out_valid, out_commit, out_cf, out_data},
          {13'd0, 1'b1, e[18], e[16], e[15:0]});
    check("R9", {31'd0, out_of}, {31'd0, e[17]});
  endtask

  initial begin
    logic [15:0] pats [3];
    logic [15:0] hold_d;
    logic        hold_c, hold_o, hold_k;
    pats[0] = 16'h8001;
    pats[1] = 16'h5A3C;
    pats[2] = 16'hFFFE;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = 2'b00;
    in_count = 8'd0;
    in_data  = 16'd0;
    in_cf    = 1'b0;
    in_of    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check("R1", {30'd0, out_valid, out_commit}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after release with no operand
    check("R1", {30'd0, out_valid, out_commit}, 32'd0);

    // Sweep: every op, counts 0..31 and the same with upper bits set.
    for (int op = 0; op < 4; op++) begin
      for (int ci = 0; ci < 64; ci++) begin
        for (int p = 0; p < 3; p++) begin
          for (int f = 0; f < 2; f++) begin
            run_vec(2'(op), (ci < 32) ? 8'(ci) : (8'(ci - 32) | 8'hE0),
                    pats[p], f[0], ~f[0]);
          end
        end
      end
    end

    // R7/R8 edge counts 16 and 17 on a distinctive operand
    run_vec(2'b10, 8'd16, 16'h1234, 1'b1, 1'b0);
    run_vec(2'b10, 8'd17, 16'h1234, 1'b1, 1'b0);
    run_vec(2'b11, 8'd16, 16'hC001, 1'b0, 1'b1);
    run_vec(2'b11, 8'd17, 16'hC001, 1'b0, 1'b1);

    // R2: outputs hold while in_valid is low, even with new inputs
    run_vec(2'b00, 8'd3, 16'h00F1, 1'b0, 1'b1);
    hold_d = out_data;
    hold_c = out_cf;
    hold_o = out_of;
    hold_k = out_commit;
    in_op    = 2'b11;
    in_count = 8'd5;
    in_data  = 16'hAAAA;
    in_cf    = 1'b1;
    in_of    = 1'b0;
    repeat (2) @(negedge clk);
    check("R2", {12'd0, out_valid, out_commit, out_cf, out_of, out_data},
          {12'd0, 1'b0, hold_k, hold_c, hold_o, hold_d});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule